// File: doc/BRIEF.md
# Serial ROM Target Controller

This block is the target end of a serial memory link. A host selects it with an active-low select line and clocks bits in and out on a serial clock. The first eight bits after select goes low form a command byte. Depending on that byte, the block does one of four things. It streams bytes from an internal byte array with a self-incrementing address, sends a fixed status byte over and over, sends a two-byte identity pair, or writes the incoming bytes into the array. The array depth is set by a parameter. The default is kept small, and the address counter wraps at the top of the array.

All four link inputs are brought into a fast system clock through two-stage synchronizers. Serial clock edges are found by comparing consecutive synchronized samples. The block never drives a real three-state pin. It produces a data bit and a separate enable, and the enable is low whenever the pin would float. An active-low pause input freezes the transaction in place, so the host can release it later and carry on where it stopped.

Top module: `serial_rom_target`

## Requirements
- R1: After reset, and while select is high, `spiMisoEn` is 0. A command is accepted only after a high-to-low transition of select. If select is held low through reset, no command is decoded until it has gone high and then low again.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first. Both select-time clock idle levels work: low (mode 0) and high (mode 3). The idle level is captured at each select fall.
- R3: Command bytes matching `0000_x011` (bit 3 ignored) start a read. Three address bytes follow, and only the low `ADDR_W` bits of the 24-bit address are used. Array bytes then leave on `spiMiso`, MSB first.
- R4: During a read, the address advances after every byte. After `2**ADDR_W-1` the next byte comes from address 0.
- R5: Command bytes matching `0000_x101` return the status value 8Ch. The value repeats from its MSB for as long as select stays low and clocks continue.
- R6: Command bytes matching `0001_x101` return 1Ch and then 83h, and that pair repeats.
- R7: Command byte 99h, followed by three address bytes, writes each subsequent full data byte into the array. The address advances after each write and wraps to 0 after the top address.
- R8: Any other command byte is ignored until the next select fall. `spiMisoEn` stays 0 and no array byte changes, even when more bytes follow.
- R9: `holdN` low while the serial clock is low starts a pause. `holdN` high while the serial clock is low ends it. During a pause, `spiMisoEn` is 0 and clock edges and input bits have no effect, so the transfer resumes at the same bit.
- R10: Output bits change only on falling serial-clock edges. The first output bit, and the enable, appear after the falling edge that follows the last command or address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Active-low select from the host |
| spiClk | input | 1 | Serial clock from the host |
| spiMosi | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low pause request |
| spiMiso | output | 1 | Serial data to the host |
| spiMisoEn | output | 1 | High when `spiMiso` is driven |

## Verification
The hardest case to reach from the ports is a pause that lands in the middle of an output byte, with the host still toggling the clock and data line. In that case the bit position and the address must both survive. The stimulus gets there in two steps. It first stops after four bits of a streamed byte, lowers `holdN` with the clock low, and toggles the clock several times with the data line high. It then releases the pause with the clock low and checks that the rest of that byte and the following byte arrive intact. A second pause, placed inside the address phase, shows that input bits arriving during a pause never reach the address register.

// File: rtl/srt_pkg.sv
package srt_pkg;

  localparam int BYTE_W   = 8;
  localparam int OPC_BITS = 8;
  localparam int ADR_BITS = 24;
  localparam int CNT_W    = $clog2(ADR_BITS);

  localparam logic [7:0] OP_MASK   = 8'hF7;  // bit 3 is a don't-care
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_IDENT  = 8'h15;
  localparam logic [7:0] OP_WRITE  = 8'h99;

  localparam logic [7:0] STATUS_VAL = 8'h8C;
  localparam logic [7:0] MAKER_VAL  = 8'h1C;
  localparam logic [7:0] DEVICE_VAL = 8'h83;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPCODE, ST_RADDR, ST_WADDR, ST_READ, ST_WRITE, ST_STATUS, ST_IDENT
  } state_e;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_MAKER, SRC_DEVICE} outSrc_e;

  typedef struct packed {
    logic    shiftIn;
    logic    shiftAddr;
    logic    writeByte;
    logic    loadOut;
    logic    shiftOut;
    outSrc_e src;
  } strobe_t;

endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csS,
  input  logic            sclkS,
  input  logic            holdS,
  input  logic [BYTE_W-1:0] nextByte,
  output strobe_t         stb,
  output logic            misoEn
);
  localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_BITS - 1);

  state_e           state;
  logic             csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0]       outCnt;
  logic             idSel, outOn, paused, modeHigh, seenRise;
  logic             rise, fall, csFall, talking;

  assign csFall  = csPrev & ~csS;
  assign rise    = ~sclkPrev & sclkS & ~paused & ~csS;
  // in mode 3 the leading edge after select is a fall with no bit behind it
  assign fall    = sclkPrev & ~sclkS & ~paused & ~csS & (~modeHigh | seenRise);
  assign talking = (state == ST_READ) || (state == ST_STATUS) || (state == ST_IDENT);
  assign misoEn  = outOn & ~paused & ~csS;

  function automatic state_e decodeOp(input logic [7:0] op);
    if ((op & OP_MASK) == OP_READ)        return ST_RADDR;
    else if ((op & OP_MASK) == OP_STATUS) return ST_STATUS;
    else if ((op & OP_MASK) == OP_IDENT)  return ST_IDENT;
    else if (op == OP_WRITE)              return ST_WADDR;
    else                                  return ST_IDLE;
  endfunction

  always_comb begin
    stb     = '0;
    stb.src = SRC_ARRAY;
    if (rise) begin
      case (state)
        ST_OPCODE:          stb.shiftIn   = 1'b1;
        ST_RADDR, ST_WADDR: stb.shiftAddr = 1'b1;
        ST_WRITE: begin
          stb.shiftIn   = 1'b1;
          stb.writeByte = (bitCnt[2:0] == 3'd7);
        end
        default: ;
      endcase
    end
    if (fall && talking) begin
      if (outCnt == 3'd0) begin
        stb.loadOut = 1'b1;
        case (state)
          ST_STATUS: stb.src = SRC_STATUS;
          ST_IDENT:  stb.src = idSel ? SRC_DEVICE : SRC_MAKER;
          default:   stb.src = SRC_ARRAY;
        endcase
      end else begin
        stb.shiftOut = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      csPrev   <= 1'b0;
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      outCnt   <= '0;
      idSel    <= 1'b0;
      outOn    <= 1'b0;
      paused   <= 1'b0;
      modeHigh <= 1'b0;
      seenRise <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
      if (csS)                              paused <= 1'b0;
      else if (!paused && !holdS && !sclkS) paused <= 1'b1;
      else if (paused && holdS && !sclkS)   paused <= 1'b0;

      if (csS) begin
        state <= ST_IDLE;
        outOn <= 1'b0;
      end else if (csFall) begin
        state    <= ST_OPCODE;
        bitCnt   <= '0;
        outCnt   <= '0;
        idSel    <= 1'b0;
        outOn    <= 1'b0;
        modeHigh <= sclkS;
        seenRise <= 1'b0;
      end else begin
        if (rise) begin
          seenRise <= 1'b1;
          bitCnt   <= bitCnt + 1'b1;
          case (state)
            ST_OPCODE: if (bitCnt == OPC_LAST) begin
              bitCnt <= '0;
              state  <= decodeOp(nextByte);
            end
            ST_RADDR: if (bitCnt == ADR_LAST) begin
              bitCnt <= '0;
              state  <= ST_READ;
            end
            ST_WADDR: if (bitCnt == ADR_LAST) begin
              bitCnt <= '0;
              state  <= ST_WRITE;
            end
            default: ;
          endcase
        end
        if (fall && talking) begin
          outCnt <= outCnt + 1'b1;
          outOn  <= 1'b1;
          if (outCnt == 3'd0 && state == ST_IDENT) idSel <= ~idSel;
        end
      end
    end
  end

  // R1: deselect silences the output on the next cycle
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csS |=> !outOn);

  // R8: an undecoded command never enables output
  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !outOn);

  // R9: the sequence position is frozen during a pause
  assert_pause_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> ($stable(bitCnt) && $stable(outCnt)));
endmodule

// File: rtl/srt_data.sv
module srt_data
  import srt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mosiS,
  input  strobe_t           stb,
  output logic [BYTE_W-1:0] nextByte,
  output logic              misoBit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] memQ, inByte, outShift;
  logic [ADDR_W-1:0] addrQ;

  assign nextByte = {inByte[BYTE_W-2:0], mosiS};
  assign misoBit  = outShift[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (stb.writeByte) mem[addrQ] <= nextByte;
    memQ <= mem[addrQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inByte   <= '0;
      outShift <= '0;
      addrQ    <= '0;
    end else begin
      if (stb.shiftIn) inByte <= nextByte;
      if (stb.shiftAddr)
        addrQ <= {addrQ[ADDR_W-2:0], mosiS};
      else if (stb.writeByte || (stb.loadOut && stb.src == SRC_ARRAY))
        addrQ <= addrQ + 1'b1;
      if (stb.loadOut) begin
        case (stb.src)
          SRC_STATUS: outShift <= STATUS_VAL;
          SRC_MAKER:  outShift <= MAKER_VAL;
          SRC_DEVICE: outShift <= DEVICE_VAL;
          default:    outShift <= memQ;
        endcase
      end else if (stb.shiftOut) begin
        outShift <= {outShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R7: each stored byte moves the address on by one, wrapping at the top
  assert_write_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.writeByte |=> (addrQ == ADDR_W'($past(addrQ) + 1'b1)));

  // R5: a status load always presents the fixed value
  assert_status_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.loadOut && stb.src == SRC_STATUS) |=> (outShift == STATUS_VAL));

  // R10: successive output bits come from the next lower position
  assert_msb_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shiftOut |=> (outShift[BYTE_W-1] == $past(outShift[BYTE_W-2])));

  // R2: input and output strobes never collide in one cycle
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.loadOut, stb.shiftOut, stb.shiftAddr, stb.writeByte}));
endmodule

// File: rtl/serial_rom_target.sv
module serial_rom_target
  import srt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spiCsN,
  input  logic spiClk,
  input  logic spiMosi,
  input  logic holdN,
  output logic spiMiso,
  output logic spiMisoEn
);
  logic [3:0]        syncQ;
  strobe_t           stb;
  logic [BYTE_W-1:0] nextByte;
  logic              misoBit, misoEnI;

  // select and clock reset low so a select held low across reset is no fall
  srt_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spiCsN, spiClk, spiMosi, holdN}),
    .q(syncQ)
  );

  srt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .csS(syncQ[3]), .sclkS(syncQ[2]), .holdS(syncQ[0]),
    .nextByte(nextByte), .stb(stb), .misoEn(misoEnI)
  );

  srt_data #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .mosiS(syncQ[1]), .stb(stb),
    .nextByte(nextByte), .misoBit(misoBit)
  );

  assign spiMiso   = misoBit & misoEnI;
  assign spiMisoEn = misoEnI;
endmodule

// File: tb/serial_rom_target_tb.sv
`timescale 1ns/1ps
module serial_rom_target_tb;
  localparam int H = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csN = 1'b0, sclk = 1'b0, mosi = 1'b0, holdN = 1'b1;
  logic miso, misoEn;
  int checks = 0, errors = 0, cycles = 0;
  logic mode3Q = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  serial_rom_target u_dut (
    .clk(clk), .rst_n(rst_n), .spiCsN(csN), .spiClk(sclk), .spiMosi(mosi),
    .holdN(holdN), .spiMiso(miso), .spiMisoEn(misoEn)
  );

  typedef struct packed {
    logic m3; logic [7:0] op; logic [23:0] adr; logic en; logic [7:0] e0; logic [7:0] e1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h03, 24'h000010, 1'b1, 8'hA5, 8'h3C},  // R3 plain read
    '{1'b1, 8'h0B, 24'hFF0011, 1'b1, 8'h3C, 8'hF0},  // R3 bit 3 and high address ignored
    '{1'b1, 8'h03, 24'h0003FF, 1'b1, 8'h77, 8'h66},  // R4 wrap past the top
    '{1'b0, 8'h05, 24'h0,      1'b1, 8'h8C, 8'h8C},  // R5
    '{1'b1, 8'h0D, 24'h0,      1'b1, 8'h8C, 8'h8C},  // R5
    '{1'b0, 8'h15, 24'h0,      1'b1, 8'h1C, 8'h83},  // R6
    '{1'b1, 8'h1D, 24'h0,      1'b1, 8'h1C, 8'h83},  // R6
    '{1'b0, 8'h07, 24'h0,      1'b0, 8'h00, 8'h00},  // R8
    '{1'b1, 8'h91, 24'h0,      1'b0, 8'h00, 8'h00}   // R8
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic selectDev(logic m3);
    mode3Q = m3; sclk = m3; waitClk(H);
    csN = 1'b0; waitClk(H);
  endtask

  task automatic deselect();
    sclk = mode3Q; waitClk(H);
    csN = 1'b1; waitClk(H);
  endtask

  task automatic xferBit(input logic b, output logic o, output logic en);
    sclk = 1'b0; mosi = b; waitClk(H);
    o = miso; en = misoEn;
    sclk = 1'b1; waitClk(H);
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx,
                          output logic allEn, output logic anyEn);
    logic o, en;
    allEn = 1'b1; anyEn = 1'b0; rx = '0;
    for (int i = 7; i >= 0; i--) begin
      xferBit(tx[i], o, en);
      rx = {rx[6:0], o}; allEn &= en; anyEn |= en;
    end
  endtask

  task automatic sendAddr(logic [23:0] a);
    logic [7:0] r; logic x, y;
    for (int i = 2; i >= 0; i--) xferByte(a[8*i +: 8], r, x, y);
  endtask

  task automatic holdPause(int pulses, output logic sawEn);
    sawEn = 1'b0; sclk = 1'b0; waitClk(H);
    holdN = 1'b0; waitClk(H);
    for (int k = 0; k < pulses; k++) begin
      mosi = 1'b1; sclk = 1'b1; waitClk(H); sawEn |= misoEn;
      sclk = 1'b0; waitClk(H); sawEn |= misoEn;
    end
    holdN = 1'b1; waitClk(H);
  endtask

  function automatic string tagOf(vec_t v);
    if ((v.op & 8'hF7) == 8'h03) return (v.adr[9:0] == 10'h3FF) ? "R4" : "R3";
    if ((v.op & 8'hF7) == 8'h05) return "R5";
    if ((v.op & 8'hF7) == 8'h15) return "R6";
    return "R8";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, r2;
    logic a0, a1, a2, n0, n1, n2, saw, o, en, o2;
    vec_t v;

    // R1: select low through reset gives no command
    waitClk(5); rst_n = 1'b1; waitClk(4);
    check("R1 reset enable", misoEn, 1'b0);
    xferByte(8'h05, r0, a0, n0); xferByte(8'h00, r0, a0, n1);
    check("R1 no fall no command", n0 | n1, 1'b0);
    sclk = 1'b0; waitClk(H); csN = 1'b1; waitClk(H);
    check("R1 deselected enable", misoEn, 1'b0);

    // R7: store bytes, then a run that wraps the address
    selectDev(1'b0); xferByte(8'h99, r0, a0, n0); sendAddr(24'h000010);
    xferByte(8'hA5, r0, a0, n0); xferByte(8'h3C, r0, a0, n0); xferByte(8'hF0, r0, a0, n0);
    deselect();
    selectDev(1'b1); xferByte(8'h99, r0, a0, n0); sendAddr(24'h0003FF);
    xferByte(8'h77, r0, a0, n0); xferByte(8'h66, r0, a0, n0);
    deselect();
    selectDev(1'b0); xferByte(8'h03, r0, a0, n0); sendAddr(24'h000000);
    xferByte(8'h00, r0, a0, n0); deselect();
    check("R7 wrapped write at 0", r0, 8'h66);

    // R8: a near-miss write code must leave the array untouched
    selectDev(1'b0); xferByte(8'h91, r0, a0, n0); sendAddr(24'h000010);
    xferByte(8'h00, r0, a0, n1); deselect();
    check("R8 no output on bad code", n0 | n1, 1'b0);
    selectDev(1'b1); xferByte(8'h03, r0, a0, n0); sendAddr(24'h000010);
    xferByte(8'h00, r0, a0, n0); deselect();
    check("R8 array unchanged", r0, 8'hA5);

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      selectDev(v.m3);
      xferByte(v.op, r0, a0, n0);
      if ((v.op & 8'hF7) == 8'h03) sendAddr(v.adr);
      xferByte(8'hFF, r0, a0, n0);
      xferByte(8'h00, r1, a1, n1);
      deselect();
      if (v.en) begin
        check($sformatf("%s vec%0d byte0", tagOf(v), i), r0, v.e0);
        check($sformatf("%s vec%0d byte1", tagOf(v), i), r1, v.e1);
        check($sformatf("%s vec%0d enable", tagOf(v), i), a0 & a1, 1'b1);
      end else begin
        check($sformatf("%s vec%0d silent", tagOf(v), i), n0 | n1, 1'b0);
      end
    end

    // R2: mode 3 read of the last stored byte
    selectDev(1'b1); xferByte(8'h03, r0, a0, n0); sendAddr(24'h000012);
    xferByte(8'h00, r0, a0, n0); deselect();
    check("R2 mode3 read", r0, 8'hF0);

    // R5: status keeps repeating
    selectDev(1'b0); xferByte(8'h05, r0, a0, n0);
    xferByte(8'h00, r0, a0, n0); xferByte(8'h00, r1, a1, n1); xferByte(8'h00, r2, a2, n2);
    deselect();
    check("R5 third status byte", r2, 8'h8C);

    // R10: enable waits for the fall, bits hold across rises
    selectDev(1'b0); xferByte(8'h03, r0, a0, n0); sendAddr(24'h000011);
    check("R10 no enable before fall", misoEn, 1'b0);
    r0 = '0; o2 = 1'b0;
    for (int i = 0; i < 8; i++) begin
      xferBit(1'b0, o, en);
      if (i == 0) check("R10 enable after fall", en, 1'b1);
      if (i == 0) o2 = miso;
      r0 = {r0[6:0], o};
    end
    deselect();
    check("R10 bit stable over rise", o2, 1'b0);
    check("R10 byte", r0, 8'h3C);

    // R9: pause inside the address and in the middle of a byte
    selectDev(1'b0); xferByte(8'h03, r0, a0, n0);
    xferByte(8'h00, r0, a0, n0);
    holdPause(5, saw);
    check("R9 addr pause silent", saw, 1'b0);
    xferByte(8'h00, r0, a0, n0); xferByte(8'h10, r0, a0, n0);
    r0 = '0;
    for (int i = 0; i < 4; i++) begin xferBit(1'b0, o, en); r0 = {r0[6:0], o}; end
    holdPause(6, saw);
    check("R9 data pause silent", saw, 1'b0);
    for (int i = 0; i < 4; i++) begin xferBit(1'b0, o, en); r0 = {r0[6:0], o}; end
    xferByte(8'h00, r1, a1, n1);
    deselect();
    check("R9 resumed byte", r0, 8'hA5);
    check("R9 following byte", r1, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule